// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register file of a small 32-bit RISC core. At any moment the instruction stream sees sixteen registers, indices 0 to 15. Behind those indices sit 27 physical 32-bit registers. The 2-bit operating mode picks which physical register answers for an index. Fast interrupt mode has its own copies of indices 8 to 14. Interrupt mode and supervisor mode each have their own copies of indices 13 and 14. Every other index maps to the shared user registers.

Each cycle the file serves two combinational operand reads and one clocked destination write. Index 15 is one shared register. Its bits [31:26] hold four condition flags and two interrupt-disable bits, bits [25:2] hold the word-aligned program counter, and bits [1:0] hold a mode field.

The register has a dedicated full-width update port, which the fetch and exception logic uses every cycle. A link strobe copies the current index-15 value into the current mode's copy of index 14, which is how a subroutine call saves its return address. Decode, the ALU, exception sequencing and memory access sit outside this block.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every physical register is cleared, except index 15, which becomes 32'h0000_0003 (mode field = supervisor). After release, every index reads zero, except index 15.
- R2: Mode encoding is 2'b00 user, 2'b01 fast interrupt, 2'b10 interrupt, 2'b11 supervisor. In user mode each index 0..14 names its own shared register: a write is read back unchanged, and different indices do not alias.
- R3: In fast interrupt mode (2'b01), indices 8..14 name private registers, separate from the user ones. Indices 0..7 name the shared registers.
- R4: In interrupt mode (2'b10), indices 13 and 14 name private registers. Every other index names the shared register.
- R5: In supervisor mode (2'b11), indices 13 and 14 name private registers, separate from both the user copies and the interrupt copies.
- R6: Reads are combinational. A read of the index being written in the same cycle returns the old value. A write lands at the rising edge only when `wr_en_i` is high.
- R7: A general write to index 15 in user mode replaces only bits [25:2]. Bits [31:26] and [1:0] keep their values.
- R8: A general write to index 15 in any privileged mode (01, 10, 11) replaces all 32 bits.
- R9: `pc_we_i` loads `pc_data_i` into index 15 at the edge. It takes priority over a general write to index 15 in the same cycle.
- R10: `link_we_i` loads the pre-edge value of index 15 into the current mode's copy of index 14. It takes priority over a general write to that same register.
- R11: Index 15 is a single register shared by all modes. Both read ports and `pc_o` show the same value in every mode. The value holds when no write reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Operating mode selecting the register bank |
| ra_idx_i | input | 4 | Index for read port A |
| rb_idx_i | input | 4 | Index for read port B |
| ra_data_o | output | 32 | Read port A data |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_idx_i | input | 4 | General write index |
| wr_data_i | input | 32 | General write data |
| pc_we_i | input | 1 | Full-width update of index 15 |
| pc_data_i | input | 32 | Data for the index-15 update |
| link_we_i | input | 1 | Copy index 15 into the mode's index 14 |
| pc_o | output | 32 | Current contents of index 15 |

## Verification
A wrong bank mapping hides until a mode switch. The bench writes through one mode and then reads the same index from the other modes. A register that is wrongly private or wrongly shared then shows the other mode's value on the next combinational read, one cycle after the write.

A merge error in index 15 appears on `pc_o` at the edge after the write, as wrong flag or mode bits. A link or priority error appears as a wrong return address on the first read of index 14 after the strobe.

// File: rtl/brf_pkg.sv
// Package: shared types and the bank mapping rule for the banked register file.
// Assumes 16 visible indices and a 27-entry physical array laid out as
// shared 0..15, fast-interrupt 8..14, interrupt 13..14, supervisor 13..14.
package brf_pkg;

    typedef enum logic [1:0] {
        MODE_USR = 2'b00,
        MODE_FIQ = 2'b01,
        MODE_IRQ = 2'b10,
        MODE_SVC = 2'b11
    } brf_mode_e;

    localparam int VIS_REGS  = 16;
    localparam int IDX_W     = $clog2(VIS_REGS);
    localparam int FIQ_FIRST = 8;
    localparam int FIQ_LAST  = 14;
    localparam int FIQ_BASE  = VIS_REGS;
    localparam int IRQ_BASE  = FIQ_BASE + (FIQ_LAST - FIQ_FIRST + 1);
    localparam int SVC_BASE  = IRQ_BASE + 2;
    localparam int PHYS_REGS = SVC_BASE + 2;
    localparam int PHYS_W    = $clog2(PHYS_REGS);
    localparam int PC_IDX    = 15;
    localparam int LINK_IDX  = 14;
    localparam int SP_IDX    = 13;

    // Translate a visible index under a mode into a physical slot.
    function automatic logic [PHYS_W-1:0] phys_of(input logic [1:0] mode,
                                                  input logic [IDX_W-1:0] idx);
        logic [PHYS_W-1:0] slot;
        slot = PHYS_W'(idx);
        case (mode)
            MODE_FIQ: begin
                if (int'(idx) >= FIQ_FIRST && int'(idx) <= FIQ_LAST)
                    slot = PHYS_W'(FIQ_BASE + int'(idx) - FIQ_FIRST);
            end
            MODE_IRQ: begin
                if (int'(idx) == SP_IDX || int'(idx) == LINK_IDX)
                    slot = PHYS_W'(IRQ_BASE + int'(idx) - SP_IDX);
            end
            MODE_SVC: begin
                if (int'(idx) == SP_IDX || int'(idx) == LINK_IDX)
                    slot = PHYS_W'(SVC_BASE + int'(idx) - SP_IDX);
            end
            default: slot = PHYS_W'(idx);
        endcase
        return slot;
    endfunction

endpackage

// File: rtl/brf_map.sv
// Module: bank lookup. Turns a visible index and the operating mode into a
// physical slot number. Purely combinational; assumes the mode is valid
// for the whole cycle.
module brf_map
    import brf_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int PW = PHYS_W
) (
    input  logic [1:0]    mode_i,
    input  logic [IW-1:0] idx_i,
    output logic [PW-1:0] phys_o
);
    // Apply the shared mapping rule from the package.
    always_comb begin
        phys_o = PW'(phys_of(mode_i, IDX_W'(idx_i)));
    end
endmodule

// File: rtl/brf_psr.sv
// Module: next-value logic for index 15 (flags, program counter, mode field).
// The dedicated update port wins over a general write. A user-mode general
// write replaces only the program counter field. Assumes DATA_W covers PC_HI.
module brf_psr
    import brf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IW     = IDX_W,
    parameter int PC_LO  = 2,
    parameter int PC_HI  = 25
) (
    input  logic [DATA_W-1:0] cur_i,
    input  logic [1:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pc_we_i,
    input  logic [DATA_W-1:0] pc_data_i,
    output logic [DATA_W-1:0] next_o
);
    localparam logic [DATA_W-1:0] PC_MASK =
        ((DATA_W'(1) << (PC_HI + 1)) - DATA_W'(1)) & ~((DATA_W'(1) << PC_LO) - DATA_W'(1));

    logic gen_hit;

    // Detect a general write addressed at index 15.
    always_comb begin
        gen_hit = wr_en_i && (int'(wr_idx_i) == PC_IDX);
    end

    // Choose the next index-15 value by priority.
    always_comb begin
        if (pc_we_i)
            next_o = pc_data_i;
        else if (gen_hit && mode_i == MODE_USR)
            next_o = (cur_i & ~PC_MASK) | (wr_data_i & PC_MASK);
        else if (gen_hit)
            next_o = wr_data_i;
        else
            next_o = cur_i;
    end
endmodule

// File: rtl/brf_store.sv
// Module: physical register array with synchronous active-low reset.
// Each slot has its own update process. Slot PC_IDX takes the value from the
// index-15 logic. The other slots take the link copy first, then the
// general write. Assumes the caller never maps a general write onto PC_IDX.
module brf_store
    import brf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREGS  = PHYS_REGS,
    parameter int PW     = PHYS_W,
    parameter int PCSLOT = PC_IDX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PW-1:0]     wr_phys_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              link_en_i,
    input  logic [PW-1:0]     link_phys_i,
    input  logic [DATA_W-1:0] pc_next_i,
    output logic [DATA_W-1:0] regs_o [NREGS]
);
    localparam logic [DATA_W-1:0] PC_RESET = DATA_W'(MODE_SVC);

    for (genvar p = 0; p < NREGS; p++) begin : g_slot
        if (p == PCSLOT) begin : g_pc
            // Hold index 15; reset leaves the mode field at supervisor.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_o[p] <= PC_RESET;
                else
                    regs_o[p] <= pc_next_i;
            end
        end else begin : g_gen
            // Update an ordinary slot: the link copy beats the general write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_o[p] <= '0;
                else if (link_en_i && link_phys_i == PW'(p))
                    regs_o[p] <= regs_o[PCSLOT];
                else if (wr_en_i && wr_phys_i == PW'(p))
                    regs_o[p] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/banked_regfile.sv
// Module: top of the mode-banked register file. Four bank lookups (read A,
// read B, write, link target) feed a 27-slot array. Index 15 goes through its
// own merge logic. Reads are combinational from the array, so a read
// during a write sees the pre-edge value. Assumes mode_i is stable per cycle.
module banked_regfile
    import brf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [3:0]        ra_idx_i,
    input  logic [3:0]        rb_idx_i,
    output logic [DATA_W-1:0] ra_data_o,
    output logic [DATA_W-1:0] rb_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pc_we_i,
    input  logic [DATA_W-1:0] pc_data_i,
    input  logic              link_we_i,
    output logic [DATA_W-1:0] pc_o
);
    localparam int NLOOK = 4;
    localparam int LK_A  = 0;
    localparam int LK_B  = 1;
    localparam int LK_W  = 2;
    localparam int LK_L  = 3;

    logic [IDX_W-1:0]  look_idx  [NLOOK];
    logic [PHYS_W-1:0] look_phys [NLOOK];
    logic [DATA_W-1:0] regs      [PHYS_REGS];
    logic [DATA_W-1:0] pc_next;
    logic              gen_wr;

    // Gather the indices that need a bank lookup.
    always_comb begin
        look_idx[LK_A] = ra_idx_i;
        look_idx[LK_B] = rb_idx_i;
        look_idx[LK_W] = wr_idx_i;
        look_idx[LK_L] = IDX_W'(LINK_IDX);
    end

    for (genvar k = 0; k < NLOOK; k++) begin : g_look
        brf_map #(.IW(IDX_W), .PW(PHYS_W)) u_map (
            .mode_i (mode_i),
            .idx_i  (look_idx[k]),
            .phys_o (look_phys[k])
        );
    end

    // Route general writes to index 15 away from the array.
    always_comb begin
        gen_wr = wr_en_i && (int'(wr_idx_i) != PC_IDX);
    end

    brf_psr #(.DATA_W(DATA_W), .IW(IDX_W)) u_psr (
        .cur_i     (regs[PC_IDX]),
        .mode_i    (mode_i),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .pc_we_i   (pc_we_i),
        .pc_data_i (pc_data_i),
        .next_o    (pc_next)
    );

    brf_store #(.DATA_W(DATA_W), .NREGS(PHYS_REGS), .PW(PHYS_W), .PCSLOT(PC_IDX)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (gen_wr),
        .wr_phys_i   (look_phys[LK_W]),
        .wr_data_i   (wr_data_i),
        .link_en_i   (link_we_i),
        .link_phys_i (look_phys[LK_L]),
        .pc_next_i   (pc_next),
        .regs_o      (regs)
    );

    // Drive the two operand reads and the index-15 view.
    always_comb begin
        ra_data_o = regs[look_phys[LK_A]];
        rb_data_o = regs[look_phys[LK_B]];
        pc_o      = regs[PC_IDX];
    end
endmodule

// File: rtl/brf_checker.sv
// Module: port-level properties of the banked register file, bound to the top.
// Assumes rst_n is driven low from time zero.
module brf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode_i,
    input logic [3:0]  ra_idx_i,
    input logic [31:0] ra_data_o,
    input logic [31:0] rb_data_o,
    input logic [3:0]  rb_idx_i,
    input logic        wr_en_i,
    input logic [3:0]  wr_idx_i,
    input logic [31:0] wr_data_i,
    input logic        pc_we_i,
    input logic [31:0] pc_data_i,
    input logic        link_we_i,
    input logic [31:0] pc_o
);
    AST_RESET_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc_o == 32'h0000_0003); // R1

    AST_USER_PC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 4'd15 && mode_i == 2'b00 && !pc_we_i) |=>
        (pc_o[31:26] == $past(pc_o[31:26]) && pc_o[1:0] == $past(pc_o[1:0])
         && pc_o[25:2] == $past(wr_data_i[25:2]))); // R7

    AST_PRIV_PC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == 4'd15 && mode_i != 2'b00 && !pc_we_i) |=>
        pc_o == $past(wr_data_i)); // R8

    AST_PC_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_i |=> pc_o == $past(pc_data_i)); // R9

    AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_i ##1 (ra_idx_i == 4'd14 && mode_i == $past(mode_i)) |->
        ra_data_o == $past(pc_o)); // R10

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_we_i && !(wr_en_i && wr_idx_i == 4'd15)) |=> $stable(pc_o)); // R11

    AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx_i == 4'd15) |-> rb_data_o == pc_o); // R11
endmodule

bind banked_regfile brf_checker u_brf_checker (.*);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [3:0]  ra_idx_i = '0, rb_idx_i = '0, wr_idx_i = '0;
    logic [31:0] ra_data_o, rb_data_o, pc_o;
    logic        wr_en_i = 1'b0, pc_we_i = 1'b0, link_we_i = 1'b0;
    logic [31:0] wr_data_i = '0, pc_data_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int          port_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    banked_regfile u_banked_regfile (.*);

    // Driver side: queue an expectation for port 0 (A), 1 (B) or 2 (pc).
    task automatic expect_port(input int port, input logic [31:0] exp, input string tag);
        port_q.push_back(port);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Read one index in one mode through port A and expect a value.
    task automatic rd(input logic [1:0] m, input logic [3:0] idx, input logic [31:0] exp,
                      input string tag);
        mode_i = m; ra_idx_i = idx;
        expect_port(0, exp, tag);
        @(negedge clk);
    endtask

    // Write one index in one mode through the general port.
    task automatic wr(input logic [1:0] m, input logic [3:0] idx, input logic [31:0] d);
        mode_i = m; wr_idx_i = idx; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Monitor: compare queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (port_q.size() > 0) begin
                int          p;
                logic [31:0] e, a;
                string       t;
                p = port_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                a = (p == 0) ? ra_data_o : (p == 1) ? rb_data_o : pc_o;
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", t, a, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 15; i++) rd(2'b00, 4'(i), 32'h0, "R1 user zero");
        rd(2'b01, 4'd9, 32'h0, "R1 fiq zero");
        expect_port(2, 32'h0000_0003, "R1 pc reset");
        rd(2'b00, 4'd15, 32'h0000_0003, "R11 idx15 read");
        // R2 user writes and read-back
        for (int i = 0; i < 15; i++) wr(2'b00, 4'(i), 32'h100 + i);
        for (int i = 0; i < 15; i++) rd(2'b00, 4'(i), 32'h100 + i, "R2 user readback");
        // R3 fast interrupt banking
        for (int i = 0; i < 8; i++) rd(2'b01, 4'(i), 32'h100 + i, "R3 fiq shared low");
        for (int i = 8; i < 15; i++) rd(2'b01, 4'(i), 32'h0, "R3 fiq private");
        wr(2'b01, 4'd9, 32'hA5A5_0009);
        rd(2'b01, 4'd9, 32'hA5A5_0009, "R3 fiq write");
        rd(2'b00, 4'd9, 32'h109, "R3 user untouched");
        // R4 interrupt banking
        rd(2'b10, 4'd13, 32'h0, "R4 irq private 13");
        rd(2'b10, 4'd12, 32'h10C, "R4 irq shared 12");
        rd(2'b10, 4'd9, 32'h109, "R4 irq shared 9");
        wr(2'b10, 4'd13, 32'h0000_1313);
        rd(2'b10, 4'd13, 32'h0000_1313, "R4 irq write");
        rd(2'b00, 4'd13, 32'h10D, "R4 user 13 untouched");
        // R5 supervisor banking
        rd(2'b11, 4'd14, 32'h0, "R5 svc private 14");
        wr(2'b11, 4'd14, 32'h0000_5E14);
        rd(2'b11, 4'd14, 32'h0000_5E14, "R5 svc write");
        rd(2'b10, 4'd14, 32'h0, "R5 irq 14 untouched");
        rd(2'b00, 4'd14, 32'h10E, "R5 user 14 untouched");
        rd(2'b11, 4'd13, 32'h0, "R5 svc 13 private");
        // R6 read during write and disabled write
        mode_i = 2'b00; ra_idx_i = 4'd3; rb_idx_i = 4'd3;
        wr_idx_i = 4'd3; wr_data_i = 32'hDEAD_0003; wr_en_i = 1'b1;
        expect_port(0, 32'h103, "R6 old value A");
        expect_port(1, 32'h103, "R6 old value B");
        @(negedge clk);
        wr_en_i = 1'b0;
        rd(2'b00, 4'd3, 32'hDEAD_0003, "R6 new value");
        wr_idx_i = 4'd4; wr_data_i = 32'hFFFF_FFFF;
        @(negedge clk);
        rd(2'b00, 4'd4, 32'h104, "R6 no write when disabled");
        // R9 dedicated update port and priority
        pc_we_i = 1'b1; pc_data_i = 32'hFC00_0042;
        @(negedge clk);
        pc_we_i = 1'b0;
        expect_port(2, 32'hFC00_0042, "R9 pc port");
        @(negedge clk);
        mode_i = 2'b11; wr_idx_i = 4'd15; wr_data_i = 32'h1234_5678; wr_en_i = 1'b1;
        pc_we_i = 1'b1; pc_data_i = 32'h0000_0101;
        @(negedge clk);
        wr_en_i = 1'b0; pc_we_i = 1'b0;
        expect_port(2, 32'h0000_0101, "R9 pc port priority");
        @(negedge clk);
        // R7 user write to index 15 touches only [25:2]
        pc_we_i = 1'b1; pc_data_i = 32'hA800_0002;
        @(negedge clk);
        pc_we_i = 1'b0;
        wr(2'b00, 4'd15, 32'h0123_4567);
        expect_port(2, 32'hA923_4566, "R7 user pc field only");
        rd(2'b00, 4'd15, 32'hA923_4566, "R7 user read idx15");
        // R8 privileged write replaces all bits; R11 sharing
        wr(2'b11, 4'd15, 32'h5555_0001);
        expect_port(2, 32'h5555_0001, "R8 svc full write");
        rd(2'b01, 4'd15, 32'h5555_0001, "R11 fiq sees idx15");
        wr(2'b10, 4'd15, 32'h3000_0F02);
        expect_port(2, 32'h3000_0F02, "R8 irq full write");
        rd(2'b10, 4'd15, 32'h3000_0F02, "R11 irq sees idx15");
        @(negedge clk);
        expect_port(2, 32'h3000_0F02, "R11 idx15 holds");
        @(negedge clk);
        // R10 link copy with priority over a general write
        mode_i = 2'b11; link_we_i = 1'b1;
        wr_idx_i = 4'd14; wr_data_i = 32'h0000_0999; wr_en_i = 1'b1;
        @(negedge clk);
        link_we_i = 1'b0; wr_en_i = 1'b0;
        rd(2'b11, 4'd14, 32'h3000_0F02, "R10 svc link priority");
        rd(2'b00, 4'd14, 32'h10E, "R10 user 14 untouched");
        mode_i = 2'b01; link_we_i = 1'b1; pc_we_i = 1'b1; pc_data_i = 32'h0000_0200;
        @(negedge clk);
        link_we_i = 1'b0; pc_we_i = 1'b0;
        rd(2'b01, 4'd14, 32'h3000_0F02, "R10 fiq link takes old pc");
        mode_i = 2'b00; link_we_i = 1'b1;
        @(negedge clk);
        link_we_i = 1'b0;
        rd(2'b00, 4'd14, 32'h0000_0200, "R10 user link");
        rd(2'b11, 4'd14, 32'h3000_0F02, "R10 svc 14 kept");
        @(negedge clk);
        #4;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule